// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C bus target that lets an external controller read and write a small bank of 8-bit registers. It watches the SCL and SDA wires, and it runs on a system clock that is at least sixteen times the SCL rate. Each wire passes through a synchronizer and a short majority filter before edge detection, so a single-sample glitch is discarded. From the filtered wires the block detects START, repeated START and STOP conditions. It answers only to the fixed 7-bit device address 0x34. It takes part in the bus only by pulling SDA low, and it never holds SCL.

A write transfer is: START, address byte with direction bit 0, pointer byte, then any number of data bytes. Each data byte goes to the register the pointer selects, and the pointer then advances by one. To read, the controller first writes the pointer. It then issues a repeated START with direction bit 1 and clocks data out from the pointed register onward. The controller acknowledges each byte it wants to continue with and leaves the last one unacknowledged. The register storage sits outside the block: the block gives a one-cycle write strobe with address and data, and reads through a combinational data input.

Top module: `i2c_reg_target`

## Requirements
- R1: A START or repeated START always makes the next byte an address byte, even in the middle of a transfer; a pointer byte sent after a repeated START and a new write address selects the register again.
- R2: A STOP ends the transfer and releases SDA; until the next START, bytes clocked on the bus are not acknowledged and cause no register write.
- R3: An address byte whose upper seven bits equal 0x34 is acknowledged by pulling SDA low while SCL is high on the ninth pulse; its least significant bit selects write (0) or read (1). The block changes its SDA drive only while SCL is low.
- R4: An address byte with any other value is not acknowledged, and the block neither drives SDA nor writes a register until the next START.
- R5: In a write, the byte after the address loads the register pointer, and the next byte (received MSB first) produces a single one-cycle write strobe with the strobe address equal to the pointer and the strobe data equal to that byte.
- R6: Every further data byte of the same write goes to the next register. The pointer advances by one after each byte and wraps from the last register to register 0.
- R7: After a repeated START with the read bit, the block sends the pointed register MSB first, with a 0 bit sent as SDA pulled low. It releases SDA during the ninth pulse so the controller can acknowledge. The pointer persists across STOP.
- R8: When the controller acknowledges a read byte, the block sends the register at the next pointer value, wrapping after the last register.
- R9: When the controller does not acknowledge a read byte, the block stops driving SDA and leaves it released for all further SCL pulses until a STOP or START.
- R10: Every byte the block receives after a matching address (pointer and data) is acknowledged on the ninth pulse.
- R11: A low pulse of one system-clock sample on SDA while SCL is high, or on SCL while it is high, is filtered out. It does not produce a START, STOP or extra bit.
- R12: After reset SDA is released and the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL wire |
| sda_i | input | 1 | Sampled level of the SDA wire |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | REG_AW | Register pointer, used for both writes and reads |
| reg_wdata_o | output | 8 | Data for the write strobe |
| reg_rdata_i | input | 8 | Contents of the register at reg_addr_o |

## Verification
Most internal faults show up at the pins within one SCL pulse. A bit counter that is off by one moves the acknowledge to the wrong pulse, and the controller sees a missing ACK in the ninth slot of that same byte. A phase state that fails to reset on a repeated START shows up one byte later, as a write strobe carrying the address byte value. A pointer fault shows up at the next strobe or read as a wrong register address or wrong data. A fault in the filter or condition detection, such as a glitch taken as a START, breaks the byte alignment of the transfer in progress. The transfer then ends with a missing write or a wrong register value.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int BYTE_W = 8;

   // activity of the target within one transfer
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK,
      PH_TX,
      PH_MACK,
      PH_IGNORE
   } phase_e;

   // meaning of the byte currently being received
   typedef enum logic [1:0] {
      BK_ADDR,
      BK_PTR,
      BK_DATA
   } byte_kind_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int TAPS        = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   localparam int HALF = TAPS / 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_line_filter: SYNC_STAGES must be at least 2");
   end
   if (TAPS < 1 || (TAPS % 2) == 0) begin : g_bad_taps
      $error("i2c_line_filter: TAPS must be odd and positive");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   if (TAPS == 1) begin : g_direct
      assign line_o = sync_q[SYNC_STAGES-1];
   end else begin : g_majority
      logic [TAPS-1:0] win_q;
      logic            out_q;
      int              ones;

      always_comb begin
         ones = 0;
         for (int i = 0; i < TAPS; i++) ones = ones + int'(win_q[i]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q <= '1;
            out_q <= 1'b1;
         end else begin
            win_q <= {win_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
            out_q <= (ones > HALF);
         end
      end

      assign line_o = out_q;

      // R11
      filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(out_q) |-> $past(ones > HALF));
   end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev,
   output logic bus_busy
);

   logic scl_q, sda_q, busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
         busy_q <= 1'b0;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
         if (start_ev)     busy_q <= 1'b1;
         else if (stop_ev) busy_q <= 1'b0;
      end
   end

   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
   assign bus_busy = busy_q;

   // R1
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> bus_busy);

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h34,
   parameter int         AW       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              bus_busy,
   output logic              sda_pull_o,
   output logic              reg_wr_o,
   output logic [AW-1:0]     reg_addr_o,
   output logic [BYTE_W-1:0] reg_wdata_o,
   input  logic [BYTE_W-1:0] reg_rdata_i
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   phase_e            phase;
   byte_kind_e        kind;
   logic [BYTE_W-1:0] sr;
   logic [CNT_W-1:0]  bitcnt;
   logic              rd_mode;
   logic              mack;
   logic              pull;
   logic              wr;
   logic [BYTE_W-1:0] wdata;
   logic [AW-1:0]     ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         kind    <= BK_ADDR;
         sr      <= '0;
         bitcnt  <= '0;
         rd_mode <= 1'b0;
         mack    <= 1'b0;
         pull    <= 1'b0;
         wr      <= 1'b0;
         wdata   <= '0;
         ptr     <= '0;
      end else begin
         wr <= 1'b0;
         if (wr) ptr <= ptr + 1'b1;
         if (start_ev) begin
            phase  <= PH_RX;
            kind   <= BK_ADDR;
            bitcnt <= '0;
            pull   <= 1'b0;
         end else if (stop_ev) begin
            phase <= PH_IDLE;
            pull  <= 1'b0;
         end else begin
            unique case (phase)
               PH_RX: begin
                  if (scl_rise && bitcnt != FULL) begin
                     sr     <= {sr[BYTE_W-2:0], sda_f};
                     bitcnt <= bitcnt + 1'b1;
                  end
                  if (scl_fall && bitcnt == FULL) begin
                     unique case (kind)
                        BK_ADDR: begin
                           if (sr[BYTE_W-1:1] == DEV_ADDR) begin
                              rd_mode <= sr[0];
                              kind    <= BK_PTR;
                              pull    <= 1'b1;
                              phase   <= PH_ACK;
                           end else begin
                              phase <= PH_IGNORE;
                           end
                        end
                        BK_PTR: begin
                           ptr   <= sr[AW-1:0];
                           kind  <= BK_DATA;
                           pull  <= 1'b1;
                           phase <= PH_ACK;
                        end
                        default: begin
                           wr    <= 1'b1;
                           wdata <= sr;
                           pull  <= 1'b1;
                           phase <= PH_ACK;
                        end
                     endcase
                  end
               end
               PH_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rd_mode) begin
                        sr    <= reg_rdata_i;
                        pull  <= ~reg_rdata_i[BYTE_W-1];
                        phase <= PH_TX;
                     end else begin
                        pull  <= 1'b0;
                        phase <= PH_RX;
                     end
                  end
               end
               PH_TX: begin
                  if (scl_rise) bitcnt <= bitcnt + 1'b1;
                  if (scl_fall) begin
                     if (bitcnt == FULL) begin
                        pull  <= 1'b0;
                        ptr   <= ptr + 1'b1;
                        phase <= PH_MACK;
                     end else begin
                        sr   <= {sr[BYTE_W-2:0], 1'b0};
                        pull <= ~sr[BYTE_W-2];
                     end
                  end
               end
               PH_MACK: begin
                  if (scl_rise) mack <= ~sda_f;
                  if (scl_fall) begin
                     if (mack) begin
                        bitcnt <= '0;
                        sr     <= reg_rdata_i;
                        pull   <= ~reg_rdata_i[BYTE_W-1];
                        phase  <= PH_TX;
                     end else begin
                        phase <= PH_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull_o  = pull;
   assign reg_wr_o    = wr;
   assign reg_addr_o  = ptr;
   assign reg_wdata_o = wdata;

   // R1
   start_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (phase == PH_RX && kind == BK_ADDR && bitcnt == '0));

   // R2
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_busy |-> !sda_pull_o);

   // R3
   drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f)) |-> $stable(sda_pull_o));

   // R4
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IGNORE) |-> (!sda_pull_o && !reg_wr_o));

   // R5
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> !reg_wr_o);

   // R6
   wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> (reg_addr_o == AW'($past(reg_addr_o) + 1'b1)));

   // R9
   nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_MACK && scl_fall && !mack && !start_ev && !stop_ev) |=> !sda_pull_o);

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h34,
   parameter int         REG_AW      = 3,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_TAPS   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   output logic              reg_wr_o,
   output logic [REG_AW-1:0] reg_addr_o,
   output logic [7:0]        reg_wdata_o,
   input  logic [7:0]        reg_rdata_i
);

   localparam int LINES = 2;

   if (REG_AW < 1 || REG_AW > BYTE_W) begin : g_bad_aw
      $error("i2c_reg_target: REG_AW must lie in 1..8");
   end

   logic [LINES-1:0] raw, filt;
   logic scl_rise, scl_fall, start_ev, stop_ev, bus_busy;

   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      i2c_line_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .TAPS        (FILT_TAPS)
      ) i_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw[g]),
         .line_o (filt[g])
      );
   end

   i2c_bus_events i_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (filt[0]),
      .sda_f    (filt[1]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .bus_busy (bus_busy)
   );

   i2c_tgt_engine #(
      .DEV_ADDR (DEV_ADDR),
      .AW       (REG_AW)
   ) i_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_f       (filt[0]),
      .sda_f       (filt[1]),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .start_ev    (start_ev),
      .stop_ev     (stop_ev),
      .bus_busy    (bus_busy),
      .sda_pull_o  (sda_pull_o),
      .reg_wr_o    (reg_wr_o),
      .reg_addr_o  (reg_addr_o),
      .reg_wdata_o (reg_wdata_o),
      .reg_rdata_i (reg_rdata_i)
   );

endmodule

// File: tb/test_i2c_reg_target.sv
`timescale 1ns/1ps
module test_i2c_reg_target;

   localparam int AW = 3;
   localparam int NREG = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_pull;
   logic reg_wr;
   logic [AW-1:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic sda_line;
   logic [7:0] rf [NREG];
   int wr_count = 0;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   assign sda_line  = sda_m & ~sda_pull;
   assign reg_rdata = rf[reg_addr];

   i2c_reg_target #(.REG_AW(AW)) i_i2c_reg_target (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .sda_pull_o  (sda_pull),
      .reg_wr_o    (reg_wr),
      .reg_addr_o  (reg_addr),
      .reg_wdata_o (reg_wdata),
      .reg_rdata_i (reg_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) rf[i] <= 8'(i * 17 + 3);
      end else if (reg_wr) begin
         rf[reg_addr] <= reg_wdata;
         wr_count <= wr_count + 1;
      end
   end

   function automatic logic [7:0] init_val(input int i);
      return 8'(i * 17 + 3);
   endfunction

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, input logic g_sda, input logic g_scl, output logic seen);
      sda_m = b;
      hold(10);
      scl_m = 1'b1;
      hold(4);
      if (g_sda) begin sda_m = 1'b0; hold(1); sda_m = b; end
      if (g_scl) begin scl_m = 1'b0; hold(1); scl_m = 1'b1; end
      hold(4);
      seen = sda_line;
      hold(6);
      scl_m = 1'b0;
      hold(6);
   endtask

   task automatic bus_start();
      sda_m = 1'b1;
      hold(6);
      scl_m = 1'b1;
      hold(12);
      sda_m = 1'b0;
      hold(12);
      scl_m = 1'b0;
      hold(6);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0;
      hold(8);
      scl_m = 1'b1;
      hold(12);
      sda_m = 1'b1;
      hold(12);
   endtask

   task automatic wr_byte(input logic [7:0] d, input logic glitch, output logic ack);
      logic seen;
      for (int i = 7; i >= 0; i--) clk_bit(d[i], glitch && d[i] && i == 3, glitch && i == 5, seen);
      clk_bit(1'b1, 1'b0, 1'b0, seen);
      ack = ~seen;
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] d, output logic rel);
      logic seen;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, 1'b0, 1'b0, seen);
         d[i] = seen;
      end
      clk_bit(~give_ack, 1'b0, 1'b0, seen);
      rel = seen;
   endtask

   task automatic t_reset();
      chk(sda_pull == 1'b0, "R12 sda released after reset", int'(sda_pull), 0);
      chk(reg_wr == 1'b0, "R12 strobe low after reset", int'(reg_wr), 0);
   endtask

   task automatic t_single_write();
      logic a;
      int c0 = wr_count;
      bus_start();
      wr_byte(8'h68, 1'b0, a);  chk(a, "R3 address 0x34 write acked", int'(a), 1);
      wr_byte(8'h02, 1'b0, a);  chk(a, "R10 pointer byte acked", int'(a), 1);
      wr_byte(8'hA5, 1'b0, a);  chk(a, "R10 data byte acked", int'(a), 1);
      bus_stop();
      chk(rf[2] == 8'hA5, "R5 register 2 written", int'(rf[2]), 'hA5);
      chk(wr_count == c0 + 1, "R5 exactly one strobe", wr_count - c0, 1);
   endtask

   task automatic t_burst_write();
      logic a;
      logic all_ack = 1'b1;
      logic [7:0] v [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
      bus_start();
      wr_byte(8'h68, 1'b0, a); all_ack &= a;
      wr_byte(8'h06, 1'b0, a); all_ack &= a;
      for (int k = 0; k < 4; k++) begin wr_byte(v[k], 1'b0, a); all_ack &= a; end
      bus_stop();
      chk(all_ack, "R10 all burst bytes acked", int'(all_ack), 1);
      chk(rf[6] == 8'h11, "R6 burst reg 6", int'(rf[6]), 'h11);
      chk(rf[7] == 8'h22, "R6 burst reg 7", int'(rf[7]), 'h22);
      chk(rf[0] == 8'h33, "R6 burst wraps to reg 0", int'(rf[0]), 'h33);
      chk(rf[1] == 8'h44, "R6 burst reg 1", int'(rf[1]), 'h44);
   endtask

   task automatic t_single_read();
      logic a, rel;
      logic [7:0] d;
      bus_start();
      wr_byte(8'h68, 1'b0, a);
      wr_byte(8'h05, 1'b0, a);
      bus_start();
      wr_byte(8'h69, 1'b0, a);  chk(a, "R3 address 0x34 read acked", int'(a), 1);
      rd_byte(1'b0, d, rel);
      bus_stop();
      chk(d == init_val(5), "R7 read reg 5", int'(d), int'(init_val(5)));
      chk(rel, "R7 SDA released in controller ack slot", int'(rel), 1);
   endtask

   task automatic t_burst_read_nack();
      logic a, rel, seen;
      logic [7:0] d;
      logic quiet = 1'b1;
      bus_start();
      wr_byte(8'h68, 1'b0, a);
      wr_byte(8'h06, 1'b0, a);
      bus_start();
      wr_byte(8'h69, 1'b0, a);
      rd_byte(1'b1, d, rel); chk(d == 8'h11, "R8 burst read reg 6", int'(d), 'h11);
      rd_byte(1'b1, d, rel); chk(d == 8'h22, "R8 burst read reg 7", int'(d), 'h22);
      rd_byte(1'b0, d, rel); chk(d == 8'h33, "R8 burst read wraps to reg 0", int'(d), 'h33);
      for (int k = 0; k < 9; k++) begin
         clk_bit(1'b1, 1'b0, 1'b0, seen);
         quiet &= seen;
      end
      chk(quiet, "R9 no drive after controller nack", int'(quiet), 1);
      bus_stop();
   endtask

   task automatic t_wrong_addr();
      logic a;
      logic any_ack = 1'b0;
      int c0 = wr_count;
      bus_start();
      wr_byte(8'h6A, 1'b0, a);  chk(!a, "R4 address 0x35 not acked", int'(a), 0);
      wr_byte(8'h03, 1'b0, a);  any_ack |= a;
      wr_byte(8'h99, 1'b0, a);  any_ack |= a;
      bus_stop();
      chk(!any_ack, "R4 later bytes not acked", int'(any_ack), 0);
      chk(wr_count == c0, "R4 no strobe", wr_count - c0, 0);
      chk(rf[3] == init_val(3), "R4 reg 3 untouched", int'(rf[3]), int'(init_val(3)));
   endtask

   task automatic t_restart_midwrite();
      logic a;
      int c0 = wr_count;
      bus_start();
      wr_byte(8'h68, 1'b0, a);
      wr_byte(8'h03, 1'b0, a);
      bus_start();
      wr_byte(8'h68, 1'b0, a);  chk(a, "R1 address after repeated start acked", int'(a), 1);
      wr_byte(8'h04, 1'b0, a);
      wr_byte(8'h3C, 1'b0, a);
      bus_stop();
      chk(rf[4] == 8'h3C, "R1 pointer reloaded after repeated start", int'(rf[4]), 'h3C);
      chk(rf[3] == init_val(3), "R1 reg 3 not written", int'(rf[3]), int'(init_val(3)));
      chk(wr_count == c0 + 1, "R1 one strobe", wr_count - c0, 1);
   endtask

   task automatic t_stop_behaviour();
      logic a, rel;
      logic [7:0] d;
      int c0;
      bus_start();
      wr_byte(8'h68, 1'b0, a);
      wr_byte(8'h01, 1'b0, a);
      bus_stop();
      chk(sda_pull == 1'b0, "R2 released after stop", int'(sda_pull), 0);
      c0 = wr_count;
      scl_m = 1'b0;
      hold(6);
      wr_byte(8'h68, 1'b0, a);
      wr_byte(8'h77, 1'b0, a);
      chk(!a && wr_count == c0, "R2 no ack or write without start", int'(a), 0);
      bus_start();
      wr_byte(8'h69, 1'b0, a);
      rd_byte(1'b0, d, rel);
      bus_stop();
      chk(d == 8'h44, "R7 pointer kept across stop", int'(d), 'h44);
   endtask

   task automatic t_glitch();
      logic a;
      int c0 = wr_count;
      bus_start();
      wr_byte(8'h68, 1'b1, a);
      wr_byte(8'h05, 1'b1, a);
      wr_byte(8'h9E, 1'b1, a);  chk(a, "R11 glitched data byte acked", int'(a), 1);
      bus_stop();
      chk(rf[5] == 8'h9E, "R11 glitches filtered", int'(rf[5]), 'h9E);
      chk(wr_count == c0 + 1, "R11 single strobe under glitches", wr_count - c0, 1);
   endtask

   initial begin
      hold(5);
      t_reset();
      rst_n = 1'b1;
      hold(10);
      t_reset();
      t_single_write();
      t_burst_write();
      t_single_read();
      t_burst_read_nack();
      t_wrong_addr();
      t_restart_midwrite();
      t_stop_behaviour();
      t_glitch();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule